// File: doc/BRIEF.md
# Deskew Lane Frame Receiver

A 16-lane parallel link carries, next to its data lanes, one extra lane that also moves one byte per clock. That extra lane repeats a 136-slot frame. The first 128 slots are copies of the data lanes: eight consecutive bytes from each lane, starting with lane 15 and stepping down to lane 0. The last eight slots are a framing pattern: two bytes of 0xF6, two bytes of 0x28, then four bytes of 0xAA. Each copied byte shows up on the extra lane one clock after the same byte appears on its own data lane.

The receiver watches the extra lane for the eight-byte framing pattern and builds frame lock from it. Once it is locked, it keeps a slot counter and reports where each frame starts and which data lane is being copied. For each copy slot it compares the extra-lane byte with the data-lane byte from one clock earlier. At the end of each eight-byte group it sets or clears that lane's bit in a mismatch vector. The block does not correct lane skew and does not buffer any data.

The sync state machine has four states. HUNT searches every byte position for the pattern. VERIFY waits one frame and checks for the pattern again at the expected slots. LOCKED means the framing is sound. COAST means the block is still locked but has seen at least one frame with bad framing. The transitions are:
- HUNT to VERIFY when the pattern is found.
- VERIFY to LOCKED when the pattern is seen again at the expected slots.
- VERIFY to HUNT when it is not.
- LOCKED to COAST when a frame's framing is bad.
- COAST to LOCKED when a frame's framing is good again.
- COAST to HUNT on the fourth bad frame in a row.

Top module: `dsk_frame_rx`

## Requirements
- R1: In HUNT the block looks for the bytes F6 F6 28 28 AA AA AA AA on eight consecutive clocks of `dsk_byte`, at any alignment. It takes the clock after the last 0xAA to be slot 0. A single pattern never asserts `locked`.
- R2: `locked` goes high when a second pattern ends exactly 136 slots after the first. It goes high on the slot-0 clock that follows that second pattern.
- R3: Slot s from 0 to 127 holds a copy of data lane 15 − floor(s/8). While locked and in such a slot, `lane_idx_vld` is 1 and `lane_idx` gives that lane. At all other times `lane_idx_vld` is 0 and `lane_idx` is 0.
- R4: `frame_start` is 1 exactly on slot-0 clocks while locked, and 0 at all other times.
- R5: While locked, the framing bytes are checked in slots 128 to 135. One to three bad frames in a row leave `locked` high. A good frame resets the count of bad frames.
- R6: The fourth bad frame in a row drops `locked` from the next clock onward. The block then needs two fresh patterns to lock again.
- R7: While locked, each copy slot compares `dsk_byte` with byte `lane_idx` of `lane_bytes` from the previous clock. Lane L is bits [8L+7:8L]. After that lane's group, `mismatch[lane]` becomes 1 if any of the eight bytes differed and 0 if none did. The new value is visible from the clock after the group's last slot. The other bits of `mismatch` hold.
- R8: While not locked, `mismatch` holds its value no matter what the lanes carry.
- R9: A synchronous reset puts the block in HUNT. From the clock after the reset edge, `locked`, `frame_start`, `lane_idx_vld`, `lane_idx` and `mismatch` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous reset, active high |
| lane_bytes | input | 128 | Current byte of each data lane; lane L is bits [8L+7:8L] |
| dsk_byte | input | 8 | Current byte of the extra (deskew) lane |
| locked | output | 1 | Frame lock held (LOCKED or COAST) |
| frame_start | output | 1 | The current deskew byte is slot 0 |
| lane_idx | output | 4 | Data lane whose copy is in the current slot |
| lane_idx_vld | output | 1 | The current slot is a copy slot while locked |
| mismatch | output | 16 | Per-lane result of the most recent group compare |

## Verification
The bench starts the stream in the middle of a copy region. This catches a design that locks on the first pattern, or that counts slot 0 one clock off: it would raise `frame_start` on the wrong clock or select the wrong lane. It corrupts a copy byte in the middle of a group and also on a group's last slot. That exposes an accumulator that drops its final byte or clears too early, and a compare against the undelayed lane byte would flag every group. It applies three bad frames, then a good one, then three more. That shows the bad-frame count really resets, and a design without a good-frame reset would drop lock. After four bad frames it corrupts the copies while unlocked and checks that `mismatch` stays frozen until a relock that needs two patterns. A reset in the middle of the run must clear everything.

// File: rtl/dsk_pkg.sv
package dsk_pkg;

    typedef enum logic [1:0] {
        ST_HUNT   = 2'd0,
        ST_VERIFY = 2'd1,
        ST_LOCKED = 2'd2,
        ST_COAST  = 2'd3
    } sync_state_t;

    localparam logic [7:0] MARK_A = 8'hF6;
    localparam logic [7:0] MARK_B = 8'h28;
    localparam logic [7:0] MARK_X = 8'hAA;

    localparam int MARK_A_LEN = 2;
    localparam int MARK_B_LEN = 2;
    localparam int MARK_X_LEN = 4;
    localparam int TRAILER_LEN = MARK_A_LEN + MARK_B_LEN + MARK_X_LEN;

    // expected byte at position pos (0 = oldest) of the framing trailer
    function automatic logic [7:0] trailer_byte(input int pos);
        if (pos < MARK_A_LEN)
            return MARK_A;
        else if (pos < MARK_A_LEN + MARK_B_LEN)
            return MARK_B;
        else
            return MARK_X;
    endfunction

endpackage

// File: rtl/dsk_frame_sync.sv
module dsk_frame_sync
    import dsk_pkg::*;
#(
    parameter int BYTE_W         = 8,
    parameter int LANES          = 16,
    parameter int GROUP          = 8,
    parameter int CONFIRM_FRAMES = 2,
    parameter int LOSS_FRAMES    = 4,
    localparam int FRAME_LEN     = LANES * GROUP + TRAILER_LEN,
    localparam int SLOT_W        = $clog2(FRAME_LEN),
    localparam int CNT_W         = $clog2(CONFIRM_FRAMES + LOSS_FRAMES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] dsk_byte,
    output logic [SLOT_W-1:0] slot,
    output logic              in_lock,
    output logic              frame_start
);

    localparam int WIN_W = TRAILER_LEN * BYTE_W;

    sync_state_t       state;
    sync_state_t       nxt;
    logic [WIN_W-1:0]  win;
    logic [WIN_W-1:0]  pattern;
    logic [WIN_W-1:0]  cand;
    logic              hdr_match;
    logic              at_end;
    logic [CNT_W-1:0]  good_cnt;
    logic [CNT_W-1:0]  miss_cnt;

    // framing pattern, oldest byte in the most significant position
    always_comb begin
        pattern = '0;
        for (int i = 0; i < TRAILER_LEN; i++)
            pattern[(TRAILER_LEN-1-i)*BYTE_W +: BYTE_W] = BYTE_W'(trailer_byte(i));
    end

    assign cand      = {win[WIN_W-BYTE_W-1:0], dsk_byte};
    assign hdr_match = (cand == pattern);
    assign at_end    = (slot == SLOT_W'(FRAME_LEN - 1));

    // history of the last deskew bytes
    always_ff @(posedge clk) begin
        if (rst)
            win <= '0;
        else
            win <= cand;
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_HUNT;
        else
            state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_HUNT: begin
                if (hdr_match)
                    nxt = (CONFIRM_FRAMES <= 1) ? ST_LOCKED : ST_VERIFY;
            end
            ST_VERIFY: begin
                if (at_end) begin
                    if (!hdr_match)
                        nxt = ST_HUNT;
                    else if (int'(good_cnt) + 1 >= CONFIRM_FRAMES)
                        nxt = ST_LOCKED;
                end
            end
            ST_LOCKED: begin
                if (at_end && !hdr_match)
                    nxt = (LOSS_FRAMES <= 1) ? ST_HUNT : ST_COAST;
            end
            ST_COAST: begin
                if (at_end) begin
                    if (hdr_match)
                        nxt = ST_LOCKED;
                    else if (int'(miss_cnt) + 1 >= LOSS_FRAMES)
                        nxt = ST_HUNT;
                end
            end
            default: nxt = ST_HUNT;
        endcase
    end

    // slot counter and frame counters
    always_ff @(posedge clk) begin
        if (rst) begin
            slot     <= '0;
            good_cnt <= '0;
            miss_cnt <= '0;
        end else begin
            unique case (state)
                ST_HUNT: begin
                    slot     <= '0;
                    good_cnt <= CNT_W'(1);
                    miss_cnt <= '0;
                end
                ST_VERIFY: begin
                    slot <= at_end ? '0 : slot + SLOT_W'(1);
                    if (at_end && hdr_match)
                        good_cnt <= good_cnt + CNT_W'(1);
                    miss_cnt <= '0;
                end
                ST_LOCKED: begin
                    slot <= at_end ? '0 : slot + SLOT_W'(1);
                    if (at_end)
                        miss_cnt <= hdr_match ? '0 : CNT_W'(1);
                end
                ST_COAST: begin
                    slot <= at_end ? '0 : slot + SLOT_W'(1);
                    if (at_end)
                        miss_cnt <= hdr_match ? '0 : miss_cnt + CNT_W'(1);
                end
                default: slot <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        in_lock     = (state == ST_LOCKED) || (state == ST_COAST);
        frame_start = in_lock && (slot == '0);
    end

endmodule

// File: rtl/dsk_lane_delay.sv
module dsk_lane_delay #(
    parameter int BYTE_W = 8,
    parameter int LANES  = 16,
    parameter int LAG    = 1,
    localparam int BUS_W = BYTE_W * LANES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [BUS_W-1:0] lanes_in,
    output logic [BUS_W-1:0] lanes_out
);

    generate
        if (LAG == 0) begin : g_direct
            assign lanes_out = lanes_in;
        end else begin : g_pipe
            logic [BUS_W-1:0] stage [LAG];
            for (genvar k = 0; k < LAG; k++) begin : g_stage
                always_ff @(posedge clk) begin
                    if (rst)
                        stage[k] <= '0;
                    else if (k == 0)
                        stage[k] <= lanes_in;
                    else
                        stage[k] <= stage[(k == 0) ? 0 : k-1];
                end
            end
            assign lanes_out = stage[LAG-1];
        end
    endgenerate

endmodule

// File: rtl/dsk_lane_compare.sv
module dsk_lane_compare #(
    parameter int BYTE_W = 8,
    parameter int LANES  = 16,
    parameter int GROUP  = 8,
    parameter int SLOT_W = 8,
    localparam int LANE_W = $clog2(LANES),
    localparam int BUS_W  = BYTE_W * LANES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic [SLOT_W-1:0] slot,
    input  logic [BYTE_W-1:0] dsk_byte,
    input  logic [BUS_W-1:0]  lanes_dly,
    output logic [LANE_W-1:0] lane_idx,
    output logic              lane_idx_vld,
    output logic [LANES-1:0]  mismatch
);

    logic              copy_slot;
    logic              grp_last;
    logic [LANE_W-1:0] lane_raw;
    logic [BYTE_W-1:0] ref_byte;
    logic              diff;
    logic              acc;

    // slot decode: group g carries lane LANES-1-g
    always_comb begin
        int g;
        int ofs;
        g         = int'(slot) / GROUP;
        ofs       = int'(slot) % GROUP;
        copy_slot = int'(slot) < LANES * GROUP;
        grp_last  = (ofs == GROUP - 1);
        lane_raw  = LANE_W'(LANES - 1 - g);
    end

    assign lane_idx_vld = active && copy_slot;
    assign lane_idx     = lane_idx_vld ? lane_raw : '0;
    assign ref_byte     = lanes_dly[lane_raw*BYTE_W +: BYTE_W];
    assign diff         = (dsk_byte != ref_byte);

    // running miscompare flag inside the current group
    always_ff @(posedge clk) begin
        if (rst || !lane_idx_vld)
            acc <= 1'b0;
        else
            acc <= grp_last ? 1'b0 : (acc | diff);
    end

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            always_ff @(posedge clk) begin
                if (rst)
                    mismatch[l] <= 1'b0;
                else if (lane_idx_vld && grp_last && (lane_raw == LANE_W'(l)))
                    mismatch[l] <= acc | diff;
            end
        end
    endgenerate

endmodule

// File: rtl/dsk_frame_rx.sv
module dsk_frame_rx #(
    parameter int BYTE_W         = 8,
    parameter int LANES          = 16,
    parameter int GROUP          = 8,
    parameter int COPY_LAG       = 1,
    parameter int CONFIRM_FRAMES = 2,
    parameter int LOSS_FRAMES    = 4,
    localparam int LANE_W        = $clog2(LANES),
    localparam int BUS_W         = BYTE_W * LANES,
    localparam int FRAME_LEN     = LANES * GROUP + dsk_pkg::TRAILER_LEN,
    localparam int SLOT_W        = $clog2(FRAME_LEN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BUS_W-1:0]  lane_bytes,
    input  logic [BYTE_W-1:0] dsk_byte,
    output logic              locked,
    output logic              frame_start,
    output logic [LANE_W-1:0] lane_idx,
    output logic              lane_idx_vld,
    output logic [LANES-1:0]  mismatch
);

    logic [SLOT_W-1:0] slot;
    logic [BUS_W-1:0]  lanes_dly;

    dsk_frame_sync #(
        .BYTE_W         (BYTE_W),
        .LANES          (LANES),
        .GROUP          (GROUP),
        .CONFIRM_FRAMES (CONFIRM_FRAMES),
        .LOSS_FRAMES    (LOSS_FRAMES)
    ) u_sync (
        .clk         (clk),
        .rst         (rst),
        .dsk_byte    (dsk_byte),
        .slot        (slot),
        .in_lock     (locked),
        .frame_start (frame_start)
    );

    dsk_lane_delay #(
        .BYTE_W (BYTE_W),
        .LANES  (LANES),
        .LAG    (COPY_LAG)
    ) u_delay (
        .clk       (clk),
        .rst       (rst),
        .lanes_in  (lane_bytes),
        .lanes_out (lanes_dly)
    );

    dsk_lane_compare #(
        .BYTE_W (BYTE_W),
        .LANES  (LANES),
        .GROUP  (GROUP),
        .SLOT_W (SLOT_W)
    ) u_cmp (
        .clk          (clk),
        .rst          (rst),
        .active       (locked),
        .slot         (slot),
        .dsk_byte     (dsk_byte),
        .lanes_dly    (lanes_dly),
        .lane_idx     (lane_idx),
        .lane_idx_vld (lane_idx_vld),
        .mismatch     (mismatch)
    );

endmodule

// File: rtl/dsk_frame_rx_chk.sv
module dsk_frame_rx_chk #(
    parameter int LANES  = 16,
    localparam int LANE_W = $clog2(LANES)
) (
    input logic              clk,
    input logic              rst,
    input logic              locked,
    input logic              frame_start,
    input logic [LANE_W-1:0] lane_idx,
    input logic              lane_idx_vld,
    input logic [LANES-1:0]  mismatch
);

    logic rst_q;

    always_ff @(posedge clk)
        rst_q <= rst;

    AST_FS_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> locked); // R4

    AST_FS_FIRST_LANE: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> (lane_idx_vld && lane_idx == LANE_W'(LANES - 1))); // R3

    AST_VLD_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
        lane_idx_vld |-> locked); // R3

    AST_LOCK_AT_SLOT0: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> frame_start); // R2

    AST_MM_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !locked |=> $stable(mismatch)); // R8

    AST_MM_ONE_LANE: assert property (@(posedge clk) disable iff (rst)
        $countones(mismatch ^ $past(mismatch)) <= 1); // R7

    always_ff @(posedge clk) begin
        if (rst_q && !rst)
            AST_RESET_CLEAR: assert (!locked && !frame_start && !lane_idx_vld
                                     && mismatch == '0); // R9
    end

endmodule

bind dsk_frame_rx dsk_frame_rx_chk #(.LANES(LANES)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .locked       (locked),
    .frame_start  (frame_start),
    .lane_idx     (lane_idx),
    .lane_idx_vld (lane_idx_vld),
    .mismatch     (mismatch)
);

// File: tb/dsk_frame_rx_tb.sv
`timescale 1ns/1ps
module dsk_frame_rx_tb;

    localparam int FRAME = 136;

    typedef struct {
        bit        lk;
        bit        fs;
        bit [3:0]  idx;
        bit        vld;
        bit [15:0] mm;
        string     tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [127:0] lane_bytes = '0;
    logic [7:0]   dsk_byte = '0;
    logic         locked, frame_start, lane_idx_vld;
    logic [3:0]   lane_idx;
    logic [15:0]  mismatch;

    exp_t  q[$];
    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 0;

    // stimulus and model state
    int           tx_slot  = 0;
    int           cyc      = 0;
    logic [127:0] prev_l   = '0;
    bit           exp_lock = 0;
    int           good_run = 0;
    int           bad_run  = 0;
    bit [15:0]    mm_exp   = '0;
    bit           grp_err  = 0;

    always #2.5 clk = ~clk;

    dsk_frame_rx u_dut (
        .clk          (clk),
        .rst          (rst),
        .lane_bytes   (lane_bytes),
        .dsk_byte     (dsk_byte),
        .locked       (locked),
        .frame_start  (frame_start),
        .lane_idx     (lane_idx),
        .lane_idx_vld (lane_idx_vld),
        .mismatch     (mismatch)
    );

    function automatic logic [127:0] gen_lanes(input int c);
        logic [127:0] v;
        for (int l = 0; l < 16; l++)
            v[l*8 +: 8] = 8'(c * 13 + l * 29 + (c >> 3) * 7) ^ 8'(l * l + 3);
        return v;
    endfunction

    function automatic logic [7:0] trailer(input int s);
        if (s < 130) return 8'hF6;
        if (s < 132) return 8'h28;
        return 8'hAA;
    endfunction

    task automatic check(input string req, input string what, input int got, input int exp,
                         input string tag);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s (phase %s): got %0h expected %0h", req, what, tag, got, exp);
        end
    endtask

    // driver: one cycle of stimulus, pushing the expected outputs of that cycle
    task automatic drive_cycle(input bit hdr_bad, input int bad_slot, input string tag);
        exp_t         e;
        logic [127:0] cur;
        logic [7:0]   b;
        int           lane;
        @(negedge clk);
        cur  = gen_lanes(cyc);
        lane = 15 - tx_slot / 8;
        if (tx_slot < 128) begin
            b = prev_l[lane*8 +: 8];
            if (tx_slot == bad_slot) b = b ^ 8'h01;
        end else begin
            b = trailer(tx_slot);
            if (hdr_bad && tx_slot == 130) b = b ^ 8'h10;
        end
        e.lk  = exp_lock;
        e.fs  = exp_lock && tx_slot == 0;
        e.vld = exp_lock && tx_slot < 128;
        e.idx = e.vld ? 4'(lane) : 4'd0;
        e.mm  = mm_exp;
        e.tag = tag;
        q.push_back(e);
        lane_bytes = cur;
        dsk_byte   = b;
        // model of this cycle's clock edge
        if (exp_lock && tx_slot < 128) begin
            grp_err = grp_err | (tx_slot == bad_slot);
            if (tx_slot % 8 == 7) begin
                mm_exp[lane] = grp_err;
                grp_err = 0;
            end
        end
        if (tx_slot == FRAME - 1) begin
            if (!exp_lock) begin
                if (!hdr_bad) begin
                    good_run++;
                    if (good_run >= 2) begin exp_lock = 1; bad_run = 0; end
                end else good_run = 0;
            end else begin
                if (!hdr_bad) bad_run = 0;
                else bad_run++;
                if (bad_run == 4) begin exp_lock = 0; good_run = 0; grp_err = 0; end
            end
        end
        tx_slot = (tx_slot + 1) % FRAME;
        prev_l  = cur;
        cyc++;
    endtask

    task automatic run_frames(input int n, input bit hdr_bad, input int bad_slot,
                              input string tag);
        for (int i = 0; i < n * FRAME; i++)
            drive_cycle(hdr_bad, bad_slot, tag);
    endtask

    task automatic do_reset(input int start_slot);
        @(negedge clk);
        rst = 1'b1;
        lane_bytes = '0;
        dsk_byte   = '0;
        repeat (3) @(negedge clk);
        #1;
        check("R9", "locked after reset", int'(locked), 0, "R9");
        check("R9", "frame_start after reset", int'(frame_start), 0, "R9");
        check("R9", "lane_idx_vld after reset", int'(lane_idx_vld), 0, "R9");
        check("R9", "mismatch after reset", int'(mismatch), 0, "R9");
        rst = 1'b0;
        prev_l = '0;
        exp_lock = 0; good_run = 0; bad_run = 0; mm_exp = '0; grp_err = 0;
        tx_slot = start_slot;
    endtask

    // monitor: compares each cycle's outputs with the queued expectation
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #1;
            if (q.size() > 0) begin
                e = q.pop_front();
                check("R2", "locked", int'(locked), int'(e.lk), e.tag);
                check("R4", "frame_start", int'(frame_start), int'(e.fs), e.tag);
                check("R3", "lane_idx_vld", int'(lane_idx_vld), int'(e.vld), e.tag);
                check("R3", "lane_idx", int'(lane_idx), int'(e.idx), e.tag);
                check("R7", "mismatch", int'(mismatch), int'(e.mm), e.tag);
            end
        end
    end

    initial begin
        do_reset(60);
        run_frames(2, 0, -1, "R1");
        run_frames(2, 0, -1, "R2");
        run_frames(1, 0, 83, "R7");       // lane 5, middle of its group
        run_frames(1, 0, -1, "R7");       // clean group clears the bit
        run_frames(1, 0, 127, "R7");      // lane 0, last slot of its group
        run_frames(1, 0, -1, "R7");
        run_frames(3, 1, -1, "R5");
        run_frames(1, 0, -1, "R5");
        run_frames(3, 1, 12, "R5");
        run_frames(1, 0, -1, "R5");
        run_frames(4, 1, 40, "R6");
        run_frames(1, 0, 20, "R8");       // unlocked: mismatch must not move
        run_frames(2, 0, -1, "R6");
        do_reset(97);
        run_frames(3, 0, -1, "R9");
        @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule